// File: doc/BRIEF.md
# Pipelined Cyclic Message Rotator

This block moves a vector of `LANES` equal-width messages between the two node groups of a quasi-cyclic LDPC decoder. Every lane reaches its destination by one common cyclic rotation, so the network is a barrel rotator rather than a full crossbar. A source select picks the concatenated variable-node messages in the first half of an iteration and the concatenated check-node messages in the second half. When the check-node vector is selected, the shift is negated modulo `LANES`, so messages travel back along the edges they came from.

The shift amount is reduced modulo `LANES`, then split into three bit groups. Each of three registered stages rotates by its own group's weight modulo `LANES`. Source select, shift and a valid flag are all sampled with the data at the pipeline entry, so every one of them may change on every cycle. The default lane count is 360 with a 9-bit shift. Any lane count of 5 or more works, and the bench uses 13.

Top module: `lane_rotator`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline register clears. Right after reset, `out_vld` is 0 and `out_vec` is all zeros until new valid words arrive.
- R2: A word presented with `in_vld` high before rising edge e appears on `out_vld`/`out_vec` right after edge e+2, which is the third edge. `out_vld` is always `in_vld` delayed by exactly three edges.
- R3: With `src_sel` = 1, the source is `var_vec`. Lane i occupies bits `[i*MSG_W +: MSG_W]`, and output lane (i+s) mod LANES carries input lane i, where s is the shift.
- R4: With `src_sel` = 0, the source is `chk_vec` and the rotation is by (LANES − s) mod LANES. Output lane i carries input lane (i+s) mod LANES.
- R5: A shift of 0 delivers the selected vector unchanged in either source setting.
- R6: A `shift_in` value of LANES or more is treated as `shift_in` − LANES before it is applied, and this holds for both directions.
- R7: Source select, shift and data may all change on every cycle. Each word is rotated with the select and shift that were sampled with it.
- R8: The source that is not selected has no effect on the output.
- R9: A cycle with `in_vld` low produces a cycle with `out_vld` low three edges later, and valid words on either side of it keep their order and contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | 1: variable-node vector, forward shift; 0: check-node vector, negated shift |
| var_vec | input | LANES*MSG_W | Concatenated variable-node messages, lane 0 in the low bits |
| chk_vec | input | LANES*MSG_W | Concatenated check-node messages, lane 0 in the low bits |
| shift_in | input | SHIFT_W | Rotation amount, $clog2(LANES) bits |
| in_vld | input | 1 | Input word is valid |
| out_vld | output | 1 | Output word is valid |
| out_vec | output | LANES*MSG_W | Rotated message vector |

## Verification
The hardest case to reach is a run of back-to-back words in which the source select and the shift both change on every cycle. In that case, three words with different directions and amounts sit in the three stages at once, and a stage that used a live input instead of its registered shift would only fail here. The bench drives such a run on consecutive cycles and compares each output word against a rotation computed from that word's own select and shift. It also sends the shift codes at or above the lane count, which only an unreduced binary value can produce, in both directions.

// File: rtl/lr_pkg.sv
package lr_pkg;

    // Source select: which node group feeds the rotator this cycle.
    typedef enum logic {
        SRC_CHK = 1'b0,
        SRC_VAR = 1'b1
    } src_e;

    localparam int NUM_STAGES = 3;

    // Lowest shift bit consumed by pipeline stage 'stage' (stage 0 = entry).
    // The entry stage takes the upper group, the last stage the lowest bits.
    function automatic int grp_lo(input int stage, input int sw);
        int g;
        g = sw / NUM_STAGES;
        return (NUM_STAGES - 1 - stage) * g;
    endfunction

    // Number of shift bits consumed by stage 'stage'; the entry stage absorbs
    // the remainder when the shift width is not a multiple of three.
    function automatic int grp_bits(input int stage, input int sw);
        int g;
        g = sw / NUM_STAGES;
        return (stage == 0) ? (sw - (NUM_STAGES - 1) * g) : g;
    endfunction

endpackage

// File: rtl/lr_src_sel.sv
module lr_src_sel
    import lr_pkg::*;
#(
    parameter int LANES   = 360,
    parameter int MSG_W   = 6,
    parameter int SHIFT_W = $clog2(LANES)
) (
    input  src_e                     src_sel,
    input  logic [LANES*MSG_W-1:0]   var_vec,
    input  logic [LANES*MSG_W-1:0]   chk_vec,
    input  logic [SHIFT_W-1:0]       shift_raw,
    output logic [LANES*MSG_W-1:0]   sel_vec,
    output logic [SHIFT_W-1:0]       eff_shift
);
    localparam logic [SHIFT_W:0] N_EXT = (SHIFT_W+1)'(LANES);

    logic [SHIFT_W:0] raw_ext;
    logic [SHIFT_W:0] wrapped;
    logic [SHIFT_W:0] eff_ext;

    always_comb begin
        raw_ext = {1'b0, shift_raw};
        // 2^SHIFT_W < 2*LANES, so a single subtraction reduces modulo LANES
        wrapped = (raw_ext >= N_EXT) ? (raw_ext - N_EXT) : raw_ext;
        if (src_sel == SRC_VAR) begin
            sel_vec = var_vec;
            eff_ext = wrapped;
        end else begin
            sel_vec = chk_vec;
            eff_ext = (wrapped == '0) ? '0 : (N_EXT - wrapped);
        end
        eff_shift = eff_ext[SHIFT_W-1:0];
        p_eff_below_lanes_r6: assert (eff_ext < N_EXT);
    end

endmodule

// File: rtl/lr_rot_stage.sv
module lr_rot_stage #(
    parameter int LANES   = 360,
    parameter int MSG_W   = 6,
    parameter int SHIFT_W = $clog2(LANES),
    parameter int LO      = 0,
    parameter int NB      = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic [LANES*MSG_W-1:0]   vec_i,
    input  logic [SHIFT_W-1:0]       shift_i,
    output logic                     vld_o,
    output logic [LANES*MSG_W-1:0]   vec_o,
    output logic [SHIFT_W-1:0]       shift_o
);
    localparam int VW    = LANES * MSG_W;
    localparam int NCAND = 1 << NB;

    logic [NB-1:0] field;
    logic [VW-1:0] cand [NCAND];

    assign field = shift_i[LO +: NB];

    // One constant rotation per value of this stage's shift group:
    // lane i moves to lane (i + (k << LO)) mod LANES.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam int AMT = (k << LO) % LANES;
        assign cand[k] = (vec_i << (AMT * MSG_W)) | (vec_i >> ((LANES - AMT) * MSG_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o   <= 1'b0;
            vec_o   <= '0;
            shift_o <= '0;
        end else begin
            vld_o   <= vld_i;
            vec_o   <= cand[field];
            shift_o <= shift_i;
        end
    end

    p_vld_follows_r9: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);
    p_vld_advances_r2: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);
    p_ones_kept_r3: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> ($countones(vec_o) == $countones($past(vec_i))));
    p_zero_group_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (vld_i && field == '0) |=> (vec_o == $past(vec_i)));

endmodule

// File: rtl/lane_rotator.sv
module lane_rotator
    import lr_pkg::*;
#(
    parameter int LANES   = 360,
    parameter int MSG_W   = 6,
    parameter int SHIFT_W = $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     src_sel,
    input  logic [LANES*MSG_W-1:0]   var_vec,
    input  logic [LANES*MSG_W-1:0]   chk_vec,
    input  logic [SHIFT_W-1:0]       shift_in,
    input  logic                     in_vld,
    output logic                     out_vld,
    output logic [LANES*MSG_W-1:0]   out_vec
);
    localparam int VW = LANES * MSG_W;

    logic               vld_s [NUM_STAGES+1];
    logic [VW-1:0]      vec_s [NUM_STAGES+1];
    logic [SHIFT_W-1:0] sh_s  [NUM_STAGES+1];

    assign vld_s[0] = in_vld;

    lr_src_sel #(
        .LANES   (LANES),
        .MSG_W   (MSG_W),
        .SHIFT_W (SHIFT_W)
    ) u_sel (
        .src_sel   (src_e'(src_sel)),
        .var_vec   (var_vec),
        .chk_vec   (chk_vec),
        .shift_raw (shift_in),
        .sel_vec   (vec_s[0]),
        .eff_shift (sh_s[0])
    );

    for (genvar j = 0; j < NUM_STAGES; j++) begin : g_stage
        lr_rot_stage #(
            .LANES   (LANES),
            .MSG_W   (MSG_W),
            .SHIFT_W (SHIFT_W),
            .LO      (grp_lo(j, SHIFT_W)),
            .NB      (grp_bits(j, SHIFT_W))
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .vld_i   (vld_s[j]),
            .vec_i   (vec_s[j]),
            .shift_i (sh_s[j]),
            .vld_o   (vld_s[j+1]),
            .vec_o   (vec_s[j+1]),
            .shift_o (sh_s[j+1])
        );
    end

    assign out_vld = vld_s[NUM_STAGES];
    assign out_vec = vec_s[NUM_STAGES];

    // Cycles since reset, so the three-deep checks never look across it
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            warm_cnt <= '0;
        else if (warm_cnt != 2'd3)
            warm_cnt <= warm_cnt + 2'd1;
    end

    p_three_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd3) |-> (out_vld == $past(in_vld, 3)));
    p_shift_travels_r7: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd3) |-> (sh_s[NUM_STAGES] == $past(sh_s[0], 3)));
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_vld && out_vec == '0));

endmodule

// File: tb/sim_lane_rotator.sv
module sim_lane_rotator;
    localparam int L  = 13;
    localparam int W  = 4;
    localparam int SW = $clog2(L);
    localparam int VW = L * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_sel = 1'b0;
    logic          in_vld = 1'b0;
    logic [VW-1:0] var_vec = '0;
    logic [VW-1:0] chk_vec = '0;
    logic [SW-1:0] shift_in = '0;
    logic          out_vld;
    logic [VW-1:0] out_vec;

    lane_rotator #(.LANES(L), .MSG_W(W)) u0 (
        .clk(clk), .rst(rst), .src_sel(src_sel), .var_vec(var_vec),
        .chk_vec(chk_vec), .shift_in(shift_in), .in_vld(in_vld),
        .out_vld(out_vld), .out_vec(out_vec)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic          h_vld [3];
    logic [VW-1:0] h_vec [3];
    string         h_tag [3];

    function automatic logic [VW-1:0] golden(input logic fwd, input logic [VW-1:0] v,
                                             input logic [VW-1:0] c, input int s);
        logic [VW-1:0] src;
        logic [VW-1:0] res;
        int e;
        src = fwd ? v : c;
        e = s % L;
        if (!fwd) e = (L - e) % L;
        res = '0;
        for (int i = 0; i < L; i++) res[((i + e) % L) * W +: W] = src[i * W +: W];
        return res;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] r;
        for (int i = 0; i < L; i++) r[i * W +: W] = W'($urandom);
        return r;
    endfunction

    task automatic compare(input string tag, input logic [VW:0] got, input logic [VW:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got vld/vec %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: check the word driven three steps ago, then drive a new one.
    task automatic step(input logic fwd, input logic [VW-1:0] v, input logic [VW-1:0] c,
                        input int s, input logic vld, input string tag);
        @(negedge clk);
        compare(h_tag[2], {out_vld, (h_vld[2] ? out_vec : {VW{1'b0}})},
                {h_vld[2], (h_vld[2] ? h_vec[2] : {VW{1'b0}})});
        h_vld[2] = h_vld[1]; h_vec[2] = h_vec[1]; h_tag[2] = h_tag[1];
        h_vld[1] = h_vld[0]; h_vec[1] = h_vec[0]; h_tag[1] = h_tag[0];
        h_vld[0] = vld;
        h_vec[0] = golden(fwd, v, c, s);
        h_tag[0] = tag;
        src_sel  = fwd;
        var_vec  = v;
        chk_vec  = c;
        shift_in = SW'(s);
        in_vld   = vld;
    endtask

    task automatic flush(input string tag);
        for (int i = 0; i < 3; i++) step(1'b1, rnd_vec(), rnd_vec(), 0, 1'b0, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            var_vec = rnd_vec(); chk_vec = rnd_vec(); in_vld = 1'b1;
            shift_in = SW'($urandom_range(0, L - 1)); src_sel = 1'b1;
        end
        @(negedge clk);
        compare("R1 reset", {out_vld, out_vec}, {1'b0, {VW{1'b0}}});
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            h_vld[i] = 1'b0; h_vec[i] = '0; h_tag[i] = "R1 after reset";
        end
        in_vld = 1'b0;
        @(negedge clk);
        compare("R1 idle", {out_vld, out_vec}, {1'b0, {VW{1'b0}}});
    endtask

    task automatic t_latency();
        step(1'b1, rnd_vec(), rnd_vec(), 5, 1'b1, "R2 single word");
        step(1'b1, rnd_vec(), rnd_vec(), 0, 1'b0, "R2 gap");
        step(1'b1, rnd_vec(), rnd_vec(), 0, 1'b0, "R2 gap");
        flush("R2 gap");
    endtask

    task automatic t_forward();
        for (int s = 0; s < L; s++) step(1'b1, rnd_vec(), rnd_vec(), s, 1'b1, "R3 forward");
        flush("R3 tail");
    endtask

    task automatic t_reverse();
        for (int s = 0; s < L; s++) step(1'b0, rnd_vec(), rnd_vec(), s, 1'b1, "R4 reverse");
        flush("R4 tail");
    endtask

    task automatic t_zero();
        step(1'b1, rnd_vec(), rnd_vec(), 0, 1'b1, "R5 zero forward");
        step(1'b0, rnd_vec(), rnd_vec(), 0, 1'b1, "R5 zero reverse");
        flush("R5 tail");
    endtask

    task automatic t_wrap();
        for (int s = L; s < (1 << SW); s++) begin
            step(1'b1, rnd_vec(), rnd_vec(), s, 1'b1, "R6 wrap forward");
            step(1'b0, rnd_vec(), rnd_vec(), s, 1'b1, "R6 wrap reverse");
        end
        flush("R6 tail");
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 24; i++)
            step(logic'(i % 2), rnd_vec(), rnd_vec(), $urandom_range(0, (1 << SW) - 1),
                 1'b1, "R7 per-cycle change");
        flush("R7 tail");
    endtask

    task automatic t_ignore();
        logic [VW-1:0] fixed;
        fixed = rnd_vec();
        step(1'b1, fixed, '0, 3, 1'b1, "R8 forward chk zero");
        step(1'b1, fixed, '1, 3, 1'b1, "R8 forward chk ones");
        step(1'b1, fixed, rnd_vec(), 3, 1'b1, "R8 forward chk random");
        step(1'b0, '1, fixed, 7, 1'b1, "R8 reverse var ones");
        step(1'b0, '0, fixed, 7, 1'b1, "R8 reverse var zero");
        flush("R8 tail");
    endtask

    task automatic t_bubble();
        logic pat [8] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        for (int i = 0; i < 8; i++)
            step(1'b1, rnd_vec(), rnd_vec(), i + 2, pat[i], "R9 bubbles");
        flush("R9 tail");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_forward();
        t_reverse();
        t_zero();
        t_wrap();
        t_mixed();
        t_ignore();
        t_bubble();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: got no completion expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule